// File: doc/BRIEF.md
# Ethernet receive frame qualifier

The block sits between a byte-wide receive MAC datapath and a receive FIFO. It takes frame bytes with start and end markers and a count of trailing bits that did not form a whole byte. Each accepted byte goes to the FIFO write port in the same cycle. When the block is set to strip the CRC, the final four bytes are held back and never written. At the end of the frame the block checks the CRC-32 and the length limits. It also records FIFO overflow and FIFO parity trouble seen during the frame. It then loads a per-frame status word and raises a maskable interrupt.

A 16-bit control word sets reception on or off, requests a halt, allows long or short frames, and selects CRC stripping or CRC bypass. It also holds six per-condition interrupt enables. Two register selects on a simple write/read port reach the control and status words. A host write to the status word clears it and drops the interrupt.

Top module: `rxq_frame_qual`

## Requirements
- R1: After reset the control word, the status word and irq_o are all zero, and no FIFO write is issued.
- R2: Control writes keep bits 0-4, 6, 8-11, 13 and 14 and read back bits 5, 7, 12 and 15 as zero (mask 0x6F5F). Any write to the status word (reg_sel_i=1) clears it and drops irq_o.
- R3: With stripping off, every accepted byte is presented on fifo_data_o with fifo_wr_o high in the cycle it arrives. fifo_last_o is high with the byte that carries in_eof_i.
- R4: The frame check sequence is the IEEE 802.3 CRC-32: reflected, preset to all ones, complemented, and appended least-significant byte first. If the frame does not match, status bit 9 is set at end of frame.
- R5: Status bit 8 (alignment) is set only when in_bits_i is non-zero on the last byte and the CRC also fails. A non-zero in_bits_i with a correct CRC leaves the frame good.
- R6: With control bit 6 set, CRC checking is off: bits 8 and 9 stay clear regardless of the frame's contents.
- R7: With control bit 4 set, the last four bytes of each frame are not written to the FIFO. The CRC is still checked, and fifo_last_o is issued with the final kept byte.
- R8: A frame longer than 1518 bytes sets status bit 11 unless control bit 2 is set. When bit 2 is set, bit 11 stays clear and the frame may be good.
- R9: A frame shorter than 64 bytes with control bit 3 clear leaves the status word and irq_o untouched. With bit 3 set it gets a normal status.
- R10: A byte that must be written while fifo_full_i is high is not written, and status bit 10 is set for that frame. A byte held back by stripping does not count.
- R11: fifo_par_err_i high during any accepted byte of a frame sets status bit 13.
- R12: Status bit 14 is set when none of bits 9, 10, 11 and 13 is set. Bit 6 and irq_o follow when (status & control & 0x6F00) is non-zero, and irq_o holds until a status write.
- R13: Clearing control bit 0 during a frame stops FIFO writes at once. On the next clock the status word becomes 0x8000.
- R14: Setting control bit 1 lets the current frame finish, with status bit 15 added to its status. Later frames are neither written nor reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A frame byte is present |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last byte of a frame |
| in_data_i | input | 8 | Frame byte |
| in_bits_i | input | 3 | Trailing bits beyond the last whole byte, valid with in_eof_i |
| fifo_full_i | input | 1 | FIFO cannot take a byte this cycle |
| fifo_par_err_i | input | 1 | FIFO internal parity error |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write byte |
| fifo_last_o | output | 1 | Written byte ends the frame |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control, 1 selects status |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Selected register contents |
| irq_o | output | 1 | Interrupt, held until a status write |

## Verification
The bench aims at the pairings that a shortcut design would get wrong. One is a partial last byte with a good CRC; a design that flags alignment on the bit count alone reports a false error there. Another is a full FIFO during a byte that stripping holds back; a design that counts overflow on raw input spuriously marks the frame. Long and short frames are sent with the allow bits both set and clear, and a late long flag or an undropped short frame shows up in the status word. Both stop mechanisms are driven mid-frame. A design that treats them alike either keeps writing after reception is disabled, or cuts a halted frame short and loses its status.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CB_EN       = 0;
  localparam int CB_HALT     = 1;
  localparam int CB_LONG_OK  = 2;
  localparam int CB_SHORT_OK = 3;
  localparam int CB_STRIP    = 4;
  localparam int CB_NOCRC    = 6;

  localparam int SB_SUM    = 6;
  localparam int SB_ALIGN  = 8;
  localparam int SB_CRC    = 9;
  localparam int SB_OVF    = 10;
  localparam int SB_LONG   = 11;
  localparam int SB_PAR    = 13;
  localparam int SB_GOOD   = 14;
  localparam int SB_HALTED = 15;

  localparam logic [15:0] CTRL_WMASK = 16'h6F5F;
  localparam logic [15:0] IRQ_MASK   = 16'h6F00;

  localparam logic [31:0] CRC_POLY_R    = 32'hEDB88320;
  // bit-reversed form of the 0xC704DD7B residue
  localparam logic [31:0] CRC_RESIDUE_R = 32'hDEBB20E3;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxq_crc32.sv
module rxq_crc32
  import rxq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_en_i,
  input  logic        first_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_next_o
);
  logic [31:0] crc_q;
  logic [31:0] crc_base;

  assign crc_base   = first_i ? '1 : crc_q;
  assign crc_next_o = crc_byte(crc_base, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= '1;
    else if (byte_en_i) crc_q <= crc_next_o;
  end
endmodule

// File: rtl/rxq_len_ctr.sv
module rxq_len_ctr #(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_en_i,
  input  logic             first_i,
  output logic [LEN_W-1:0] prev_o,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] cnt_q;

  assign prev_o = first_i ? '0 : cnt_q;
  assign len_o  = (&prev_o) ? prev_o : prev_o + LEN_W'(1);  // saturate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (byte_en_i) cnt_q <= len_o;
  end
endmodule

// File: rtl/rxq_hold_line.sv
module rxq_hold_line #(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] data_i,
  output logic [7:0] oldest_o
);
  logic [DEPTH-1:0][7:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (push_i) begin
      stage_q[0] <= data_i;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign oldest_o = stage_q[DEPTH-1];
endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
  import rxq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        stat_load_i,
  input  logic [15:0] stat_new_i,
  output logic [15:0] ctrl_o,
  output logic [15:0] status_o,
  output logic        irq_o
);
  logic [15:0] ctrl_q, status_q;
  logic        irq_q;
  logic        clr;

  assign clr = reg_wr_i & reg_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (reg_wr_i && !reg_sel_i) ctrl_q <= reg_wdata_i & CTRL_WMASK;
      // frame result wins over a same-cycle clear
      if (stat_load_i) status_q <= stat_new_i;
      else if (clr)    status_q <= '0;
      irq_q <= (irq_q & ~clr) | (stat_load_i & stat_new_i[SB_SUM]);
    end
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/rxq_frame_qual.sv
module rxq_frame_qual
  import rxq_pkg::*;
#(
  parameter int MAX_LEN   = 1518,
  parameter int MIN_LEN   = 64,
  parameter int FCS_BYTES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_sof_i,
  input  logic        in_eof_i,
  input  logic [7:0]  in_data_i,
  input  logic [2:0]  in_bits_i,
  input  logic        fifo_full_i,
  input  logic        fifo_par_err_i,
  output logic        fifo_wr_o,
  output logic [7:0]  fifo_data_o,
  output logic        fifo_last_o,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int LEN_W = $clog2(MAX_LEN + 2);

  logic [15:0]      ctrl_r, status_r, stat_new, frame_stat;
  logic             in_frame_q, ovf_q, par_q;
  logic             rx_en, rx_open, strip, start, take, done, abort;
  logic             emit, ovf_now, ovf_acc, par_acc;
  logic             crc_bad, too_long, short_rej, stat_load;
  logic [31:0]      crc_next;
  logic [LEN_W-1:0] prev_cnt, len_now;
  logic [7:0]       held_byte;

  assign rx_en   = ctrl_r[CB_EN];
  assign rx_open = rx_en & ~ctrl_r[CB_HALT];
  assign strip   = ctrl_r[CB_STRIP];

  // a new frame needs open reception; a running one only needs enable
  assign start = in_valid_i & in_sof_i & ~in_frame_q & rx_open;
  assign take  = in_valid_i & rx_en & (in_frame_q | start);
  assign done  = take & in_eof_i;
  assign abort = in_frame_q & ~rx_en;

  rxq_crc32 u_crc (
    .clk_i, .rst_ni,
    .byte_en_i (take),
    .first_i   (start),
    .data_i    (in_data_i),
    .crc_next_o(crc_next)
  );

  rxq_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk_i, .rst_ni,
    .byte_en_i(take),
    .first_i  (start),
    .prev_o   (prev_cnt),
    .len_o    (len_now)
  );

  rxq_hold_line #(.DEPTH(FCS_BYTES)) u_hold (
    .clk_i, .rst_ni,
    .push_i  (take),
    .data_i  (in_data_i),
    .oldest_o(held_byte)
  );

  assign emit        = ~strip | (prev_cnt >= LEN_W'(FCS_BYTES));
  assign fifo_wr_o   = take & emit & ~fifo_full_i;
  assign fifo_data_o = strip ? held_byte : in_data_i;
  assign fifo_last_o = fifo_wr_o & in_eof_i;

  assign ovf_now = take & emit & fifo_full_i;
  assign ovf_acc = (ovf_q & ~start) | ovf_now;
  assign par_acc = (par_q & ~start) | (take & fifo_par_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      ovf_q      <= 1'b0;
      par_q      <= 1'b0;
    end else begin
      if (abort)     in_frame_q <= 1'b0;
      else if (take) in_frame_q <= ~in_eof_i;
      if (take) begin
        ovf_q <= ovf_acc;
        par_q <= par_acc;
      end
    end
  end

  assign crc_bad   = ~ctrl_r[CB_NOCRC] & (crc_next != CRC_RESIDUE_R);
  assign too_long  = (len_now > LEN_W'(MAX_LEN)) & ~ctrl_r[CB_LONG_OK];
  assign short_rej = (len_now < LEN_W'(MIN_LEN)) & ~ctrl_r[CB_SHORT_OK];

  always_comb begin
    frame_stat            = '0;
    frame_stat[SB_CRC]    = crc_bad;
    frame_stat[SB_ALIGN]  = crc_bad & (|in_bits_i);
    frame_stat[SB_OVF]    = ovf_acc;
    frame_stat[SB_LONG]   = too_long;
    frame_stat[SB_PAR]    = par_acc;
    frame_stat[SB_GOOD]   = ~(crc_bad | ovf_acc | too_long | par_acc);
    frame_stat[SB_SUM]    = |(frame_stat & ctrl_r & IRQ_MASK);
    frame_stat[SB_HALTED] = ctrl_r[CB_HALT];
  end

  always_comb begin
    stat_new = frame_stat;
    if (abort) begin
      stat_new             = '0;
      stat_new[SB_HALTED]  = 1'b1;
    end
  end

  assign stat_load = (done & ~short_rej) | abort;

  rxq_csr u_csr (
    .clk_i, .rst_ni,
    .reg_wr_i, .reg_sel_i, .reg_wdata_i,
    .stat_load_i(stat_load),
    .stat_new_i (stat_new),
    .ctrl_o     (ctrl_r),
    .status_o   (status_r),
    .irq_o      (irq_o)
  );

  assign reg_rdata_o = reg_sel_i ? status_r : ctrl_r;
endmodule

// File: rtl/rxq_frame_qual_chk.sv
module rxq_frame_qual_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        fifo_full_i,
  input logic        fifo_wr_o,
  input logic        fifo_last_o,
  input logic        reg_wr_i,
  input logic        reg_sel_i,
  input logic [15:0] reg_rdata_o,
  input logic        irq_o,
  input logic        rx_en_i
);
  p_wr_needs_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> in_valid_i);

  p_last_is_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_last_o |-> fifo_wr_o);

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !fifo_wr_o);

  p_ctrl_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> ((reg_rdata_o & 16'h90A0) == 16'h0000));

  p_align_needs_crc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && reg_rdata_o[8]) |-> reg_rdata_o[9]);

  p_good_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && reg_rdata_o[14]) |-> ((reg_rdata_o & 16'h2F00) == 16'h0000));

  p_irq_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_wr_i && reg_sel_i)) |=> irq_o);

  p_off_no_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> !fifo_wr_o);
endmodule

bind rxq_frame_qual rxq_frame_qual_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .fifo_full_i (fifo_full_i),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_last_o (fifo_last_o),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .rx_en_i     (ctrl_r[0])
);

// File: tb/rxq_frame_qual_test.sv
module rxq_frame_qual_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic [2:0] in_bits = 0;
  logic fifo_full = 0, fifo_par = 0;
  logic fifo_wr, fifo_last;
  logic [7:0] fifo_data;
  logic reg_wr = 0, reg_sel = 1;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic irq;

  always #10 clk = ~clk;

  rxq_frame_qual uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .in_data_i(in_data), .in_bits_i(in_bits),
    .fifo_full_i(fifo_full), .fifo_par_err_i(fifo_par),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data), .fifo_last_o(fifo_last),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0, wr_cnt = 0;
  bit mon_on = 0, finished = 0;
  logic [15:0] ctrl_m = 0, exp_status = 0;
  bit exp_irq = 0;
  logic [7:0] fr[$];
  localparam logic [15:0] CE = 16'h6F01;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (fifo_wr === 1'b1) wr_cnt++;
    if (mon_on) begin
      chk(irq === exp_irq, "R12 irq per clock", 32'(irq), 32'(exp_irq));
      if (reg_sel) chk(reg_rdata === exp_status, "R12 status per clock", 32'(reg_rdata), 32'(exp_status));
    end
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = ((c[0] ^ fr[i][b]) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic build(input int n, input int seed, input bit good);
    logic [31:0] f;
    fr.delete();
    for (int k = 0; k < n - 4; k++) fr.push_back(8'((k * 37 + seed) & 255));
    f = ref_crc(n - 4);
    for (int k = 0; k < 4; k++) fr.push_back(f[8*k +: 8]);
    if (!good) fr[2] = fr[2] ^ 8'h5A;
  endtask

  task automatic wr_reg(input bit sel, input logic [15:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0; reg_sel = 1;
    if (!sel) ctrl_m = d & 16'h6F5F;
    else begin exp_status = 0; exp_irq = 0; end
  endtask

  task automatic send(input int bits, input int full_at, input int par_at, input bit model, input bit fchk);
    int n = fr.size();
    bit acc, strip, ovf = 0, par = 0, emit, ew, drop, crc_ok, bad;
    logic [15:0] s;
    logic [31:0] f;
    acc = ctrl_m[0] && !ctrl_m[1];
    strip = ctrl_m[4];
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == n - 1);
      in_bits = (i == n - 1) ? 3'(bits) : 3'd0;
      fifo_full = (i == full_at); fifo_par = (i == par_at);
      @(negedge clk);
      emit = acc && (!strip || i >= 4);
      ew = emit && (i != full_at);
      if (emit && i == full_at) ovf = 1;
      if (acc && i == par_at) par = 1;
      if (fchk) begin
        chk(fifo_wr === ew, strip ? "R7 write strobe" : "R3/R10 write strobe", 32'(fifo_wr), 32'(ew));
        if (ew) begin
          chk(fifo_data === (strip ? fr[i-4] : fr[i]), strip ? "R7 data" : "R3 data",
              32'(fifo_data), 32'(strip ? fr[i-4] : fr[i]));
          chk(fifo_last === (i == n - 1), "R3/R7 last flag", 32'(fifo_last), 32'(i == n - 1));
        end
      end
      @(posedge clk); #2;
    end
    in_valid = 0; in_sof = 0; in_eof = 0; in_bits = 0; fifo_full = 0; fifo_par = 0;
    if (model && acc) begin
      f = ref_crc(n - 4);
      crc_ok = (n >= 5) && ({fr[n-1], fr[n-2], fr[n-3], fr[n-4]} == f);
      bad = !ctrl_m[6] && !crc_ok;
      s = 0;
      s[9] = bad; s[8] = bad && bits != 0; s[10] = ovf; s[13] = par;
      s[11] = (n > 1518) && !ctrl_m[2];
      s[14] = (s == 0);
      s[6] = ((s & ctrl_m & 16'h6F00) != 0);
      s[15] = ctrl_m[1];
      drop = (n < 64) && !ctrl_m[3];
      if (!drop) begin
        exp_status = s;
        if (s[6]) exp_irq = 1;
      end
    end
  endtask

  task automatic expect_stat(input string req, input logic [15:0] st, input bit iq);
    @(negedge clk);
    chk(reg_rdata === st, req, 32'(reg_rdata), 32'(st));
    chk(irq === iq, req, 32'(irq), 32'(iq));
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int wc0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reg_rdata === 16'h0, "R1 status in reset", 32'(reg_rdata), 0);
    chk(irq === 1'b0, "R1 irq in reset", 32'(irq), 0);
    chk(fifo_wr === 1'b0, "R1 no write in reset", 32'(fifo_wr), 0);
    #3 rst_n = 1;
    @(posedge clk); #2;
    reg_sel = 0;
    @(negedge clk);
    chk(reg_rdata === 16'h0, "R1 control after reset", 32'(reg_rdata), 0);
    @(posedge clk); #2;
    reg_sel = 1;
    mon_on = 1;

    wr_reg(0, 16'hFFFF);
    reg_sel = 0;
    @(negedge clk);
    chk(reg_rdata === 16'h6F5F, "R2 reserved control bits", 32'(reg_rdata), 32'h6F5F);
    @(posedge clk); #2;
    reg_sel = 1;
    wr_reg(0, CE);

    build(64, 1, 1); send(0, -1, -1, 1, 1);
    expect_stat("R4/R12 good frame", 16'h4040, 1);
    wr_reg(1, 0);
    expect_stat("R2 status clear", 16'h0000, 0);

    build(80, 2, 0); send(0, -1, -1, 1, 1);
    expect_stat("R4 crc error", 16'h0240, 1);
    wr_reg(1, 0);

    build(90, 3, 0); send(3, -1, -1, 1, 1);
    expect_stat("R5 alignment error", 16'h0340, 1);
    wr_reg(1, 0);
    build(90, 4, 1); send(5, -1, -1, 1, 1);
    expect_stat("R5 partial byte with good crc", 16'h4040, 1);
    wr_reg(1, 0);

    wr_reg(0, CE | 16'h0040);
    build(72, 5, 0); send(2, -1, -1, 1, 1);
    expect_stat("R6 crc ignored", 16'h4040, 1);
    wr_reg(1, 0);

    wr_reg(0, CE | 16'h0010);
    build(70, 6, 1); send(0, -1, -1, 1, 1);
    expect_stat("R7 strip good", 16'h4040, 1);
    wr_reg(1, 0);
    build(70, 7, 1); send(0, 2, -1, 1, 1);
    expect_stat("R10 held byte not overflow", 16'h4040, 1);
    wr_reg(1, 0);
    build(70, 8, 0); send(0, -1, -1, 1, 1);
    expect_stat("R7 strip still checks crc", 16'h0240, 1);
    wr_reg(1, 0);

    wr_reg(0, CE);
    build(1519, 9, 1); send(0, -1, -1, 1, 1);
    expect_stat("R8 long frame", 16'h0840, 1);
    wr_reg(1, 0);
    build(1518, 10, 1); send(0, -1, -1, 1, 1);
    expect_stat("R8 max length good", 16'h4040, 1);
    wr_reg(1, 0);
    wr_reg(0, CE | 16'h0004);
    build(1519, 11, 1); send(0, -1, -1, 1, 1);
    expect_stat("R8 long allowed", 16'h4040, 1);
    wr_reg(1, 0);

    wr_reg(0, CE);
    build(20, 12, 1); send(0, -1, -1, 1, 1);
    expect_stat("R9 short dropped", 16'h0000, 0);
    build(63, 13, 0); send(0, -1, -1, 1, 1);
    expect_stat("R9 short bad dropped", 16'h0000, 0);
    wr_reg(0, CE | 16'h0008);
    build(20, 14, 1); send(0, -1, -1, 1, 1);
    expect_stat("R9 short allowed", 16'h4040, 1);
    wr_reg(1, 0);

    wr_reg(0, CE);
    build(100, 15, 1); send(0, 10, -1, 1, 1);
    expect_stat("R10 overflow", 16'h0440, 1);
    wr_reg(1, 0);
    build(100, 16, 1); send(0, -1, 30, 1, 1);
    expect_stat("R11 parity error", 16'h2040, 1);
    wr_reg(1, 0);

    wr_reg(0, 16'h0001);
    build(80, 17, 0); send(0, -1, -1, 1, 1);
    expect_stat("R12 masked crc error", 16'h0200, 0);
    wr_reg(1, 0);

    wr_reg(0, CE);
    mon_on = 0;
    build(100, 18, 1);
    fork
      send(0, -1, -1, 0, 0);
      begin
        repeat (20) @(posedge clk);
        #2;
        wr_reg(0, 16'h6F00);
        wc0 = wr_cnt;
      end
    join
    chk(wr_cnt == wc0, "R13 no write after disable", 32'(wr_cnt), 32'(wc0));
    exp_status = 16'h8000; exp_irq = 0;
    expect_stat("R13 abort status", 16'h8000, 0);
    mon_on = 1;
    wr_reg(1, 0);
    wr_reg(0, CE);
    build(64, 19, 1); send(0, -1, -1, 1, 1);
    expect_stat("R13 recovery frame", 16'h4040, 1);
    wr_reg(1, 0);

    build(100, 20, 1);
    fork
      send(0, -1, -1, 1, 1);
      begin
        repeat (20) @(posedge clk);
        #2;
        wr_reg(0, CE | 16'h0002);
      end
    join
    expect_stat("R14 halted after frame", 16'hC040, 1);
    wc0 = wr_cnt;
    build(64, 21, 1); send(0, -1, -1, 1, 1);
    chk(wr_cnt == wc0, "R14 no write while halted", 32'(wr_cnt), 32'(wc0));
    expect_stat("R14 status unchanged while halted", 16'hC040, 1);
    wr_reg(1, 0);
    expect_stat("R2 clear after halt", 16'h0000, 0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule